// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block decides whether a phase-locked loop has settled. It watches the divided reference clock and the divided feedback clock at the inputs of the phase-frequency detector and samples both with a fast clock. For each pair of rising edges it measures the gap in sampling-clock cycles, counting from whichever edge comes first. The pair passes when the gap fits inside a window. The window width is chosen by a 2-bit code.

Each passing pair adds to a run of consecutive passes. When five passing pairs have come in a row, the block raises a registered lock flag. The flag stays high while pairs keep passing. One failed pair clears the run and drops the flag at the same clock edge. Both divided clocks must already be synchronous to the sampling clock.

Top module: `pll_lock_detector`

## Requirements
- R1: A rising edge on an input is a sampling cycle in which that input is 1 and was 0 on the previous cycle. An input held high produces no further edges.
- R2: The window code `win_sel_i` maps codes 0, 1, 2 and 3 to an allowed separation W of 1, 2, 4 and 8 sampling cycles.
- R3: A pair passes when the second edge comes d cycles after the first, with d <= W. Either input may lead. Edges on both inputs in the same cycle pass, with d = 0.
- R4: A pair fails in the cycle W cycles after its first edge if the other input has not risen by that cycle.
- R5: A pair also fails if the leading input rises again before the other input has risen. That new edge then opens a fresh pair.
- R6: `lock_o` rises at the clock edge that samples the fifth consecutive passing pair.
- R7: Any failing pair clears the run of passes, and `lock_o` is low after that clock edge.
- R8: The pass count saturates at five. While pairs keep passing, `lock_o` stays high. In cycles with no completed pair, `lock_o` does not change.
- R9: A synchronous active-high reset leaves `lock_o` low, the pass count at zero and no pair open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ref_div_i | input | 1 | Divided reference clock, synchronous to clk_i |
| fb_div_i | input | 1 | Divided feedback clock, synchronous to clk_i |
| win_sel_i | input | 2 | Window code (0..3 gives 1, 2, 4 or 8 cycles) |
| lock_o | output | 1 | Registered lock flag |

## Verification
The assertions assume three things about the inputs:
- The divided clocks are already synchronous to the sampling clock.
- Each divided clock stays low for at least one sampled cycle between rising edges.
- The window code is stable while a pair is open.

The stimulus meets all three:
- It drives every input on the falling edge of the sampling clock.
- It builds the divided clocks as square waves of even period, high for half the period.
- It changes the window code only between whole runs of periods.

It also holds both inputs low through reset, so no spurious edge appears when reset is released.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

    localparam int DEF_SEL_W       = 2;
    localparam int DEF_PASS_TARGET = 5;

    typedef enum logic [1:0] {
        PAIR_IDLE     = 2'd0,
        PAIR_WAIT_FB  = 2'd1,
        PAIR_WAIT_REF = 2'd2
    } pair_state_e;

    typedef struct packed {
        logic ref_rise;
        logic fb_rise;
    } edge_pair_t;

    typedef struct packed {
        logic pass;
        logic fail;
    } cmp_result_t;

    // Largest window for a code of sel_w bits: 2**(2**sel_w - 1)
    function automatic int max_window(input int sel_w);
        return 1 << ((1 << sel_w) - 1);
    endfunction

endpackage

// File: rtl/lock_edge_det.sv
module lock_edge_det #(
    parameter int N = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_ch
        always_ff @(posedge clk_i) begin
            if (rst_i) prev_q[g] <= 1'b0;
            else       prev_q[g] <= sig_i[g];
        end
        assign rise_o[g] = sig_i[g] & ~prev_q[g];
    end
endmodule

// File: rtl/lock_pair_meas.sv
module lock_pair_meas
    import pll_lock_pkg::*;
#(
    parameter int SEL_W = DEF_SEL_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  edge_pair_t       edges_i,
    input  logic [SEL_W-1:0] win_sel_i,
    output cmp_result_t      res_o
);
    localparam int MAX_WIN = max_window(SEL_W);
    localparam int CNT_W   = $clog2(MAX_WIN + 1);

    pair_state_e      state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [CNT_W-1:0] win;
    logic             lead_again, lag_in;

    assign win = CNT_W'(1) << win_sel_i;

    // In a waiting state, name the edges by role, not by input
    always_comb begin
        if (state_q == PAIR_WAIT_FB) begin
            lead_again = edges_i.ref_rise;
            lag_in     = edges_i.fb_rise;
        end else begin
            lead_again = edges_i.fb_rise;
            lag_in     = edges_i.ref_rise;
        end
    end

    always_comb begin
        state_n    = state_q;
        cnt_n      = cnt_q;
        res_o.pass = 1'b0;
        res_o.fail = 1'b0;
        unique case (state_q)
            PAIR_IDLE: begin
                if (edges_i.ref_rise && edges_i.fb_rise) begin
                    res_o.pass = 1'b1;
                end else if (edges_i.ref_rise) begin
                    state_n = PAIR_WAIT_FB;
                    cnt_n   = CNT_W'(1);
                end else if (edges_i.fb_rise) begin
                    state_n = PAIR_WAIT_REF;
                    cnt_n   = CNT_W'(1);
                end
            end
            PAIR_WAIT_FB, PAIR_WAIT_REF: begin
                if (lag_in) begin
                    res_o.pass = 1'b1;
                    if (lead_again) cnt_n = CNT_W'(1);
                    else            state_n = PAIR_IDLE;
                end else if (lead_again) begin
                    res_o.fail = 1'b1;
                    cnt_n      = CNT_W'(1);
                end else if (cnt_q == win) begin
                    res_o.fail = 1'b1;
                    state_n    = PAIR_IDLE;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            default: state_n = PAIR_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= PAIR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end
endmodule

// File: rtl/lock_streak.sv
module lock_streak
    import pll_lock_pkg::*;
#(
    parameter int PASS_TARGET = DEF_PASS_TARGET
) (
    input  logic                                 clk_i,
    input  logic                                 rst_i,
    input  cmp_result_t                          res_i,
    output logic [$clog2(PASS_TARGET+1)-1:0]     streak_o,
    output logic                                 lock_o
);
    localparam int ST_W = $clog2(PASS_TARGET + 1);
    localparam logic [ST_W-1:0] TARGET = ST_W'(PASS_TARGET);

    logic [ST_W-1:0] streak_q, streak_n;
    logic            lock_q;

    always_comb begin
        streak_n = streak_q;
        if (res_i.fail)                          streak_n = '0;
        else if (res_i.pass && streak_q < TARGET) streak_n = streak_q + ST_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            streak_q <= '0;
            lock_q   <= 1'b0;
        end else begin
            streak_q <= streak_n;
            lock_q   <= (streak_n == TARGET);
        end
    end

    assign streak_o = streak_q;
    assign lock_o   = lock_q;
endmodule

// File: rtl/pll_lock_detector.sv
module pll_lock_detector
    import pll_lock_pkg::*;
#(
    parameter int SEL_W       = DEF_SEL_W,
    parameter int PASS_TARGET = DEF_PASS_TARGET
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             ref_div_i,
    input  logic             fb_div_i,
    input  logic [SEL_W-1:0] win_sel_i,
    output logic             lock_o
);
    localparam int ST_W = $clog2(PASS_TARGET + 1);

    logic [1:0]       rise;
    edge_pair_t       edges;
    cmp_result_t      res;
    logic             pass_ev, fail_ev;
    logic [ST_W-1:0]  streak;

    lock_edge_det #(.N(2)) u_edge (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .sig_i  ({ref_div_i, fb_div_i}),
        .rise_o (rise)
    );

    assign edges.ref_rise = rise[1];
    assign edges.fb_rise  = rise[0];

    lock_pair_meas #(.SEL_W(SEL_W)) u_meas (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .edges_i   (edges),
        .win_sel_i (win_sel_i),
        .res_o     (res)
    );

    assign pass_ev = res.pass;
    assign fail_ev = res.fail;

    lock_streak #(.PASS_TARGET(PASS_TARGET)) u_streak (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .res_i    (res),
        .streak_o (streak),
        .lock_o   (lock_o)
    );
endmodule

// File: rtl/pll_lock_detector_chk.sv
module pll_lock_detector_chk #(
    parameter int ST_W = 3,
    parameter int PASS_TARGET = 5
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic            lock_o,
    input logic            pass_ev,
    input logic            fail_ev,
    input logic [ST_W-1:0] streak
);
    // R3/R4/R5: one pair never passes and fails in the same cycle
    a_r3_single_verdict: assert property (@(posedge clk_i) disable iff (rst_i)
        !(pass_ev && fail_ev));

    // R7: a failing pair drops the lock flag at that clock edge
    a_r7_fail_unlocks: assert property (@(posedge clk_i) disable iff (rst_i)
        fail_ev |=> !lock_o);

    // R6: the lock flag only rises when a passing pair was sampled
    a_r6_rise_needs_pass: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(lock_o) |-> $past(pass_ev));

    // R8: a pass while locked keeps the flag high
    a_r8_hold_on_pass: assert property (@(posedge clk_i) disable iff (rst_i)
        (lock_o && pass_ev) |=> lock_o);

    // R8: no completed pair, no change in the flag
    a_r8_quiet_stable: assert property (@(posedge clk_i) disable iff (rst_i)
        (!pass_ev && !fail_ev) |=> $stable(lock_o));

    // R8: the pass count never goes past its target
    a_r8_saturate: assert property (@(posedge clk_i) disable iff (rst_i)
        int'(streak) <= PASS_TARGET);
endmodule

bind pll_lock_detector pll_lock_detector_chk #(
    .ST_W(ST_W), .PASS_TARGET(PASS_TARGET)
) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .lock_o  (lock_o),
    .pass_ev (pass_ev),
    .fail_ev (fail_ev),
    .streak  (streak)
);

// File: tb/sim_pll_lock_detector.sv
module sim_pll_lock_detector;
    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic       ref_div_i = 1'b0;
    logic       fb_div_i = 1'b0;
    logic [1:0] win_sel_i = 2'd0;
    logic       lock_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference model state
    int  cyc = 0;
    bit  m_pr = 0, m_pf = 0;
    int  m_pend = 0;      // 0 none, 1 reference leads, 2 feedback leads
    int  m_t0 = 0;
    int  m_streak = 0;
    bit  m_lock = 0;

    always #5 clk_i = ~clk_i;

    pll_lock_detector u0 (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .ref_div_i (ref_div_i),
        .fb_div_i  (fb_div_i),
        .win_sel_i (win_sel_i),
        .lock_o    (lock_o)
    );

    task automatic check(input bit act, input bit exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: lock actual %0b expected %0b",
                     req, cyc, act, exp);
        end
    endtask

    // Model the verdict of the cycle whose inputs are (r, f)
    task automatic model(input bit r, input bit f, input int sel);
        bit rr, rf;
        int w, verdict;
        rr = r && !m_pr;
        rf = f && !m_pf;
        w  = 1 << sel;
        verdict = 0;
        if (m_pend == 0) begin
            if (rr && rf)  verdict = 1;
            else if (rr) begin m_pend = 1; m_t0 = cyc; end
            else if (rf) begin m_pend = 2; m_t0 = cyc; end
        end else begin
            bit lead, lag;
            lead = (m_pend == 1) ? rr : rf;
            lag  = (m_pend == 1) ? rf : rr;
            if (lag) begin
                verdict = 1;
                if (lead) m_t0 = cyc; else m_pend = 0;
            end else if (lead) begin
                verdict = 2; m_t0 = cyc;
            end else if (cyc - m_t0 >= w) begin
                verdict = 2; m_pend = 0;
            end
        end
        if (verdict == 2)                     m_streak = 0;
        else if (verdict == 1 && m_streak < 5) m_streak++;
        m_lock = (m_streak >= 5);
        m_pr = r;
        m_pf = f;
    endtask

    // One sampling cycle: check the previous result, then drive new inputs
    task automatic step(input bit r, input bit f, input int sel, input string req);
        @(negedge clk_i);
        check(lock_o, m_lock, req);
        cyc++;
        ref_div_i = r;
        fb_div_i  = f;
        win_sel_i = 2'(sel);
        model(r, f, sel);
    endtask

    task automatic run(input int periods, input int per, input int off,
                       input int sel, input bit fb_on, input string req);
        for (int c = 0; c < periods * per; c++) begin
            bit r, f;
            r = (c % per) < per / 2;
            f = fb_on && (((c - off + per * 100) % per) < per / 2);
            step(r, f, sel, req);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        check(lock_o, 1'b0, "R9 reset");
        rst_i = 1'b0;

        // R3 R6: aligned edges, W=2, lock after five passes
        run(8, 10, 0, 1, 1, "R6 aligned lock");
        step(0, 0, 1, "R6");
        check(lock_o, 1'b1, "R6 locked after aligned pairs");
        // R3 R8: gap equal to window still passes, lock held
        run(6, 10, 2, 1, 1, "R8 boundary hold");
        check(lock_o, 1'b1, "R3 gap equal to W=2");
        // R4 R7: gap one past window fails
        run(3, 10, 3, 1, 1, "R4 gap over W");
        check(lock_o, 1'b0, "R7 unlocked after over-window gap");
        // R2 R3: widest window, feedback lagging 8 then leading 5
        run(7, 20, 8, 3, 1, "R2 W=8 lag");
        check(lock_o, 1'b1, "R2 code 3 accepts 8 cycles");
        run(7, 20, -5, 3, 1, "R3 feedback leads");
        check(lock_o, 1'b1, "R3 feedback leads within W");
        // R1: inputs held high, no edges, lock unchanged
        for (int i = 0; i < 30; i++) step(1, 1, 3, "R1 held high");
        step(0, 0, 3, "R1");
        check(lock_o, 1'b1, "R1 no edge while held high");
        // R2: narrowest window
        run(7, 10, 1, 0, 1, "R2 W=1 pass");
        check(lock_o, 1'b1, "R2 code 0 accepts 1 cycle");
        run(3, 10, 2, 0, 1, "R2 W=1 fail");
        check(lock_o, 1'b0, "R2 code 0 rejects 2 cycles");
        // R5: leading input repeats with no feedback
        run(7, 10, 0, 2, 1, "R5 relock");
        run(4, 4, 0, 3, 0, "R5 lead repeats");
        check(lock_o, 1'b0, "R5 repeated lead edge fails");
        // R9: reset in the middle of a locked run
        run(7, 10, 0, 2, 1, "R9 relock");
        @(negedge clk_i);
        rst_i = 1'b1; ref_div_i = 0; fb_div_i = 0;
        m_pr = 0; m_pf = 0; m_pend = 0; m_streak = 0; m_lock = 0;
        @(negedge clk_i);
        rst_i = 1'b0;
        check(lock_o, 1'b0, "R9 reset clears lock");
        run(6, 10, 0, 2, 1, "R9 after reset");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule